// File: doc/BRIEF.md
# Burst Mode Entry and Exit Controller

This block sequences the low-power burst operation of a current-mode power converter controller. Four digital flags come in from feedback comparators. One flag shows the feedback signal below the burst entry level. The others show it above the wake level (3.5 V), below the sleep level (3.2 V) and above the exit level (4.0 V). From these flags the block drives four outputs: a burst indicator, an enable for the internal bias, a select for the reduced current limit, and a gate that allows PWM switching.

In normal operation the block keeps a blanking counter. The counter stays at zero while the feedback is above the entry level. It counts while the feedback stays below that level. Burst is entered only when the window has run its full length without interruption. The window length is `CLK_FREQ_HZ / 1000 * BLANK_MS` clock cycles, so the default is 20 ms at 50 MHz.

Inside burst, the bias is switched on at the wake level and off at the sleep level. This makes the feedback signal move as a sawtooth between the two levels. A feedback signal above the exit level returns the block to normal operation at once.

All inputs are plain level flags sampled on the rising clock edge. The outputs are decoded from registered state, so they change one clock edge after the deciding sample.

Top module: `burst_ctrl`

## Requirements
- R1: While reset is active and after it is released, the block is in normal operation: burst_flag_o=0, bias_en_o=1, ilim_low_o=0, pwm_allow_o=1.
- R2: Burst is entered at the rising edge that samples fb_lo_entry_i high for the N-th consecutive cycle in normal operation, where N = CLK_FREQ_HZ/1000*BLANK_MS.
- R3: A sample with fb_lo_entry_i low in normal operation clears the blanking count. No burst follows unless N new consecutive low-feedback samples occur.
- R4: On entry to burst, burst_flag_o=1, ilim_low_o=1, bias_en_o=0 and pwm_allow_o=0 (the sleeping burst phase).
- R5: In the sleeping burst phase, fb_hi_wake_i=1 (with no exit) moves the block to the active burst phase: bias_en_o=1, pwm_allow_o=1, ilim_low_o=1, burst_flag_o=1.
- R6: In the active burst phase, fb_lo_sleep_i=1 (with no exit) returns the block to the sleeping phase: bias_en_o=0, pwm_allow_o=0, burst flag still 1.
- R7: In either burst phase, fb_hi_exit_i=1 returns the block to normal operation (R1 output values, full current limit) at the next edge.
- R8: When fb_hi_exit_i=1 in the same cycle as fb_hi_wake_i or fb_lo_sleep_i, the exit wins.
- R9: Inside burst, fb_lo_entry_i has no effect. fb_lo_sleep_i in the sleeping phase and fb_hi_wake_i in the active phase leave the outputs unchanged. In normal operation the wake, sleep and exit flags have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fb_lo_entry_i | input | 1 | Feedback below burst entry level |
| fb_hi_wake_i | input | 1 | Feedback above wake level |
| fb_lo_sleep_i | input | 1 | Feedback below sleep level |
| fb_hi_exit_i | input | 1 | Feedback above exit level |
| burst_flag_o | output | 1 | Burst operation active |
| bias_en_o | output | 1 | Internal bias enable |
| ilim_low_o | output | 1 | Reduced current limit select |
| pwm_allow_o | output | 1 | PWM switching allowed |

## Verification
The assertions check these properties on every cycle:
- the blanking count clears on any high-feedback sample and never passes its limit;
- burst starts only after the timer reports expiry, and starts with the bias off;
- wake, sleep and exit each give the next phase they require;
- exit wins when flags coincide.

Some behaviours only the bench scenarios can show:
- the exact cycle of entry after N uninterrupted samples;
- the restart of the window after an interruption one cycle short of expiry;
- the sawtooth alternation over many wake and sleep pairs;
- the absence of any effect from ignored flags.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_SLEEP  = 2'd1,
    ST_ACTIVE = 2'd2
  } burst_state_e;
endpackage

// File: rtl/burst_blank_timer.sv
module burst_blank_timer #(
  parameter int unsigned LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic low_i,
  output logic expire_o
);
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign expire_o = arm_i && low_i && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (!arm_i || !low_i || expire_o) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  // R3
  clear_on_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !low_i |=> (cnt == '0));

  // R2
  no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

// File: rtl/burst_fsm.sv
module burst_fsm
  import burst_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         expire_i,
  input  logic         wake_i,
  input  logic         sleep_i,
  input  logic         exit_i,
  output burst_state_e state_o
);
  burst_state_e state, nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_RUN:    if (expire_i) nxt = ST_SLEEP;
      ST_SLEEP:  if (exit_i) nxt = ST_RUN; else if (wake_i) nxt = ST_ACTIVE;
      ST_ACTIVE: if (exit_i) nxt = ST_RUN; else if (sleep_i) nxt = ST_SLEEP;
      default:   nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_RUN;
    else state <= nxt;
  end

  assign state_o = state;

  // R2
  entry_needs_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && !expire_i) |=> (state == ST_RUN));

  // R7
  exit_to_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_RUN && exit_i) |=> (state == ST_RUN));

  // R8
  exit_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_RUN && exit_i && (wake_i || sleep_i)) |=> (state == ST_RUN));

  // R5
  wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLEEP && wake_i && !exit_i) |=> (state == ST_ACTIVE));

  // R6
  sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACTIVE && sleep_i && !exit_i) |=> (state == ST_SLEEP));
endmodule

// File: rtl/burst_out_decode.sv
module burst_out_decode
  import burst_pkg::*;
(
  input  burst_state_e state_i,
  output logic         burst_flag_o,
  output logic         bias_en_o,
  output logic         ilim_low_o,
  output logic         pwm_allow_o
);
  always_comb begin
    burst_flag_o = (state_i != ST_RUN);
    ilim_low_o   = (state_i != ST_RUN);
    bias_en_o    = (state_i != ST_SLEEP);
    pwm_allow_o  = (state_i != ST_SLEEP);
  end
endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ = 50_000_000,
  parameter int unsigned BLANK_MS    = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fb_lo_entry_i,
  input  logic fb_hi_wake_i,
  input  logic fb_lo_sleep_i,
  input  logic fb_hi_exit_i,
  output logic burst_flag_o,
  output logic bias_en_o,
  output logic ilim_low_o,
  output logic pwm_allow_o
);
  localparam int unsigned BLANK_CYCLES = CLK_FREQ_HZ / 1000 * BLANK_MS;

  burst_state_e state;
  logic         expire;
  logic         armed;

  assign armed = (state == ST_RUN);

  burst_blank_timer #(.LIMIT(BLANK_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm_i    (armed),
    .low_i    (fb_lo_entry_i),
    .expire_o (expire)
  );

  burst_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .expire_i (expire),
    .wake_i   (fb_hi_wake_i),
    .sleep_i  (fb_lo_sleep_i),
    .exit_i   (fb_hi_exit_i),
    .state_o  (state)
  );

  burst_out_decode u_dec (
    .state_i      (state),
    .burst_flag_o (burst_flag_o),
    .bias_en_o    (bias_en_o),
    .ilim_low_o   (ilim_low_o),
    .pwm_allow_o  (pwm_allow_o)
  );

  // R4
  entry_bias_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_flag_o) |-> (!bias_en_o && !pwm_allow_o && ilim_low_o));

  // R9
  entry_flag_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_flag_o && !fb_hi_exit_i && !fb_hi_wake_i && !fb_lo_sleep_i)
      |=> ($stable(bias_en_o) && burst_flag_o));
endmodule

// File: tb/test_burst_ctrl.sv
module test_burst_ctrl;
  localparam int unsigned FHZ = 10_000;
  localparam int unsigned BMS = 20;
  localparam int unsigned N   = FHZ / 1000 * BMS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic be = 1'b0, wk = 1'b0, sl = 1'b0, ex = 1'b0;
  logic flag, bias, ilim, pwm;

  int checks = 0;
  int errors = 0;
  int m_state = 0;   // 0 normal, 1 sleeping burst, 2 active burst
  int m_cnt = 0;
  int unsigned seed;

  always #10 clk = ~clk;

  burst_ctrl #(.CLK_FREQ_HZ(FHZ), .BLANK_MS(BMS)) i_burst_ctrl (
    .clk(clk), .rst_n(rst_n),
    .fb_lo_entry_i(be), .fb_hi_wake_i(wk), .fb_lo_sleep_i(sl), .fb_hi_exit_i(ex),
    .burst_flag_o(flag), .bias_en_o(bias), .ilim_low_o(ilim), .pwm_allow_o(pwm)
  );

  function automatic logic [3:0] exp_out(input int st);
    case (st)
      1:       return 4'b1010;  // flag, bias, ilim, pwm
      2:       return 4'b1111;
      default: return 4'b0101;
    endcase
  endfunction

  function automatic string pick_tag(input int st, input logic b, w, s, x, input int cnt);
    if (st == 0) return (b && cnt == N-1) ? "R4" : (b ? "R2" : "R3");
    if (x) return ((st == 1 && w) || (st == 2 && s)) ? "R8" : "R7";
    if (st == 1) return w ? "R5" : "R9";
    return s ? "R6" : "R9";
  endfunction

  task automatic compare(input string tag);
    logic [3:0] e, a;
    e = exp_out(m_state);
    a = {flag, bias, ilim, pwm};
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s: outputs actual=%b expected=%b", tag, a, e);
    end
  endtask

  task automatic step(input logic b, w, s, x);
    string tag;
    @(negedge clk);
    be = b; wk = w; sl = s; ex = x;
    tag = pick_tag(m_state, b, w, s, x, m_cnt);
    @(posedge clk);
    case (m_state)
      0: if (!b) m_cnt = 0;
         else if (m_cnt == N-1) begin m_cnt = 0; m_state = 1; end
         else m_cnt++;
      1: if (x) m_state = 0; else if (w) m_state = 2;
      default: if (x) m_state = 0; else if (s) m_state = 1;
    endcase
    #5;
    compare(tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    seed = $urandom(32'd4711);
    // R1: reset state, with flags asserted
    be = 1'b1; wk = 1'b1; ex = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1");
    be = 1'b0; wk = 1'b0; ex = 1'b0;
    rst_n = 1'b1;
    @(posedge clk); #5;
    compare("R1");

    // R9: wake/sleep/exit ignored in normal operation
    step(0, 1, 0, 0); step(0, 0, 1, 0); step(0, 0, 0, 1);
    // R3: interrupt one cycle short, then restart
    for (int i = 0; i < N-1; i++) step(1, 0, 0, 0);
    step(0, 0, 0, 0);
    for (int i = 0; i < N-1; i++) step(1, 0, 0, 0);
    // R2/R4: the N-th sample enters burst
    step(1, 0, 0, 0);
    // R9: entry flag ignored in burst, sleep ignored while sleeping
    step(1, 0, 0, 0); step(0, 0, 1, 0);
    // R5, R9, R6 sawtooth
    for (int i = 0; i < 3; i++) begin
      step(0, 1, 0, 0); step(0, 1, 0, 0); step(0, 0, 1, 0);
    end
    // R8: exit together with wake
    step(0, 1, 0, 1);
    for (int i = 0; i < N; i++) step(1, 0, 0, 0);
    step(0, 1, 0, 0);
    // R8: exit together with sleep in active phase
    step(0, 0, 1, 1);
    // R7: plain exit from sleeping phase
    for (int i = 0; i < N; i++) step(1, 0, 0, 0);
    step(0, 0, 0, 1);

    // constrained random mix
    for (int i = 0; i < 6000; i++) begin
      logic b, w, s, x;
      b = (($urandom % 1000) < 996);
      w = (($urandom % 100) < 30);
      s = (($urandom % 100) < 30);
      x = (($urandom % 1000) < 15);
      step(b, w, s, x);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule